// File: doc/BRIEF.md
# I2C Bus-Clear Sequencer

This block frees an I2C bus that a slave has left stuck with SDA held low. It does so by taking over the two bus wires through open-drain pull-down enables. A pull-down enable that is asserted pulls the wire low. An enable that is deasserted lets the wire float high. The block clocks SCL nine times while leaving SDA free. That gives a slave in the middle of a byte enough edges to finish shifting and let go of SDA. The block then builds a stop condition step by step and checks whether SDA is high at the end.

A transfer engine raises the start strobe when SDA has not come free within its short pre-transfer wait. Each phase of the sequence is held for a fixed number of system clock cycles, taken from the half-period input at the moment the start is accepted. A typical setting is the count for about 5 µs. If SDA is already high when the start arrives, the block runs no sequence and reports success at once. When the block finishes, it gives a one-cycle done pulse and a fail flag. The fail flag tells the caller to abort the pending transfer with a bus-busy error.

Top module: `i2c_busclr`

## Requirements
- R1: After reset, and whenever busy is low, both pull-down enables are deasserted (0), and busy, done and fail are 0.
- R2: An accepted start produces exactly NPULSE (default 9) separate intervals in which the SCL pull-down is asserted. The SDA pull-down stays deasserted from the start through the end of the last of these intervals.
- R3: Every phase lasts D cycles, where D is the half-period input captured at acceptance, and a value of 0 is treated as 1. Busy goes high in the cycle after the accepting edge and stays high for exactly (2·NPULSE+4)·D cycles.
- R4: The phases run in this order, each phase shown as (SCL pull-down, SDA pull-down):
  - NPULSE pairs of (0,0) followed by (1,0);
  - then (1,0), a gap;
  - then (1,1), SDA low;
  - then (0,1), SCL high;
  - then (0,0), SDA high.
  
  As a result, SDA is released only while SCL is released, which forms a stop condition.
- R5: Done is high for exactly one cycle, the first cycle after busy falls. Fail in that cycle equals the inverse of SDA sampled on the last clock edge of the final phase. Fail holds its value until the next accepted start.
- R6: A start strobe raised while busy is high has no effect: the enable waveform and the busy length are unchanged.
- R7: Changes to the half-period input while busy is high do not alter the phase lengths of the sequence in progress.
- R8: A start seen while idle with SDA high runs no sequence. Busy stays 0, done is 1 for one cycle in the next cycle, and fail is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a bus clear (sampled while idle) |
| half_period_i | input | CNT_W | Cycles per phase of the sequence |
| sda_i | input | 1 | Sampled SDA line level |
| scl_drive_o | output | 1 | SCL pull-down enable (1 = pull low) |
| sda_drive_o | output | 1 | SDA pull-down enable (1 = pull low) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| fail_o | output | 1 | SDA still low after the sequence |

## Verification
The sequence is run with phase lengths of 1, 3 and 2 cycles, and with a length of 0. The zero case shows whether zero is clamped to one cycle or wraps the counter. Every cycle is compared against the expected enable pair. The pulse count shows whether the pulse loop stops at nine. A slave model that never releases SDA, compared with one that releases it partway through, tells apart the fail and success reports. A run with a start strobe and a half-period change in mid-sequence tells whether busy-time inputs leak into the waveform. A start with SDA already free checks the immediate-success path.

// File: rtl/busclr_pkg.sv
// Package: shared phase encoding for the bus-clear sequencer.
// Assumes: all sequencer modules import this package.
package busclr_pkg;

    // Phases of the bus-clear sequence, in the order they run.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_CLK_HI = 3'd1,
        PH_CLK_LO = 3'd2,
        PH_GAP    = 3'd3,
        PH_SDA_LO = 3'd4,
        PH_SCL_HI = 3'd5,
        PH_SDA_HI = 3'd6
    } clr_phase_t;

endpackage

// File: rtl/busclr_timer.sv
// Module: phase timer. It captures the phase length when a sequence is
// accepted and counts each phase down from that length.
// Assumes: load_i is high for one cycle at each phase entry; when start_i is
// also high, the new length is captured in the same cycle.
module busclr_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             load_i,
    input  logic             run_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] len_eff;
    logic [CNT_W-1:0] cnt_q;

    // Clamp a zero length to one cycle.
    always_comb len_eff = (len_i == '0) ? CNT_W'(1) : len_i;

    // Capture the phase length at acceptance; hold it while running.
    always_ff @(posedge clk) begin
        if (!rst_n)       len_q <= CNT_W'(1);
        else if (start_i) len_q <= len_eff;
    end

    // Count the current phase down from its length minus one.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load_i && start_i)    cnt_q <= len_eff - CNT_W'(1);
        else if (load_i)               cnt_q <= len_q - CNT_W'(1);
        else if (cnt_q != '0)          cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expire_o = run_i && (cnt_q == '0);

    // R3: the count never exceeds the captured length.
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < len_q);

    // R7: the captured length is steady while a sequence runs.
    a_r7_len_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !start_i && $past(run_i)) |-> $stable(len_q));
endmodule

// File: rtl/busclr_fsm.sv
// Module: sequencing state machine. It walks the clock pulses and the stop
// steps, and reports done/fail.
// Assumes: expire_i marks the last cycle of the current phase.
module busclr_fsm
    import busclr_pkg::*;
#(
    parameter int NPULSE = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       sda_i,
    input  logic       expire_i,
    output clr_phase_t phase_o,
    output logic       accept_o,
    output logic       load_o,
    output logic       done_o,
    output logic       fail_o
);
    localparam int PW = $clog2(NPULSE + 1);

    clr_phase_t      phase_q, phase_d;
    logic [PW-1:0]   pulse_q;
    logic            skip;

    assign accept_o = (phase_q == PH_IDLE) && start_i && !sda_i;
    assign skip     = (phase_q == PH_IDLE) && start_i && sda_i;
    assign load_o   = accept_o || (expire_i && phase_q != PH_SDA_HI);
    assign phase_o  = phase_q;

    // Choose the next phase.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (accept_o) phase_d = PH_CLK_HI;
            PH_CLK_HI: if (expire_i) phase_d = PH_CLK_LO;
            PH_CLK_LO: if (expire_i)
                           phase_d = (pulse_q == PW'(NPULSE - 1)) ? PH_GAP : PH_CLK_HI;
            PH_GAP:    if (expire_i) phase_d = PH_SDA_LO;
            PH_SDA_LO: if (expire_i) phase_d = PH_SCL_HI;
            PH_SCL_HI: if (expire_i) phase_d = PH_SDA_HI;
            PH_SDA_HI: if (expire_i) phase_d = PH_IDLE;
            default:                 phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Count the completed SCL low phases.
    always_ff @(posedge clk) begin
        if (!rst_n || accept_o)                       pulse_q <= '0;
        else if (phase_q == PH_CLK_LO && expire_i)    pulse_q <= pulse_q + PW'(1);
    end

    // Done pulse and sticky fail result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            fail_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (accept_o) fail_o <= 1'b0;
            if (skip) begin
                done_o <= 1'b1;
                fail_o <= 1'b0;
            end else if (phase_q == PH_SDA_HI && expire_i) begin
                done_o <= 1'b1;
                fail_o <= !sda_i;
            end
        end
    end

    // R2: the pulse count never runs past the configured number.
    a_r2_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q <= PW'(NPULSE));

    // R5: done lasts a single cycle.
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: a start with SDA free reports success without leaving idle.
    a_r8_skip_ok: assert property (@(posedge clk) disable iff (!rst_n)
        skip |=> (done_o && !fail_o && phase_q == PH_IDLE));
endmodule

// File: rtl/busclr_drive.sv
// Module: maps the phase to the open-drain pull-down enables and to busy.
// Assumes: 1 on an enable pulls the wire low; 0 releases it.
module busclr_drive
    import busclr_pkg::*;
(
    input  clr_phase_t phase_i,
    output logic       scl_drive_o,
    output logic       sda_drive_o,
    output logic       busy_o
);
    // Decode the wire levels for each phase.
    always_comb begin
        scl_drive_o = 1'b0;
        sda_drive_o = 1'b0;
        busy_o      = 1'b1;
        unique case (phase_i)
            PH_IDLE:   busy_o = 1'b0;
            PH_CLK_HI: ;
            PH_CLK_LO: scl_drive_o = 1'b1;
            PH_GAP:    scl_drive_o = 1'b1;
            PH_SDA_LO: begin scl_drive_o = 1'b1; sda_drive_o = 1'b1; end
            PH_SCL_HI: sda_drive_o = 1'b1;
            PH_SDA_HI: ;
            default:   busy_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_busclr.sv
// Module: top of the I2C bus-clear sequencer. It clocks SCL NPULSE times with
// SDA free, builds a stop condition and reports whether SDA came free.
// Assumes: sda_i is already synchronised to clk.
module i2c_busclr
    import busclr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NPULSE = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] half_period_i,
    input  logic             sda_i,
    output logic             scl_drive_o,
    output logic             sda_drive_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o
);
    clr_phase_t phase;
    logic       accept;
    logic       load;
    logic       expire;

    busclr_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (accept),
        .len_i    (half_period_i),
        .load_i   (load),
        .run_i    (busy_o),
        .expire_o (expire)
    );

    busclr_fsm #(.NPULSE(NPULSE)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .sda_i    (sda_i),
        .expire_i (expire),
        .phase_o  (phase),
        .accept_o (accept),
        .load_o   (load),
        .done_o   (done_o),
        .fail_o   (fail_o)
    );

    busclr_drive u_drive (
        .phase_i     (phase),
        .scl_drive_o (scl_drive_o),
        .sda_drive_o (sda_drive_o),
        .busy_o      (busy_o)
    );

    // R1: both wires are released whenever the block is idle.
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_drive_o && !sda_drive_o));

    // R4: SDA is released only while SCL is released (stop, never start).
    a_r4_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_drive_o) |-> !scl_drive_o);

    // R6: a start during a sequence does not shorten the busy period.
    a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !(phase == PH_SDA_HI && expire)) |=> busy_o);
endmodule

// File: tb/i2c_busclr_bench.sv
module i2c_busclr_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 16;
    localparam int NPULSE = 9;
    localparam int NPH    = 2 * NPULSE + 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] half_period_i = '0;
    logic             hold = 1'b0;
    logic             sda_i;
    logic             scl_drive_o, sda_drive_o, busy_o, done_o, fail_o;

    int total = 0;
    int bad   = 0;

    // Open-drain SDA: low if this block or the stuck slave pulls it.
    assign sda_i = !(sda_drive_o || hold);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_busclr #(.CNT_W(CNT_W), .NPULSE(NPULSE)) u_i2c_busclr (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_period_i(half_period_i),
        .sda_i(sda_i), .scl_drive_o(scl_drive_o), .sda_drive_o(sda_drive_o),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected (scl, sda) pull-down enables for phase index p.
    function automatic logic [1:0] exp_drive(input int p);
        if (p < 2 * NPULSE) return (p % 2 == 1) ? 2'b10 : 2'b00;
        case (p - 2 * NPULSE)
            0: return 2'b10;
            1: return 2'b11;
            2: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check_reset();
        @(negedge clk);
        check("R1 scl", int'(scl_drive_o), 0);
        check("R1 sda", int'(sda_drive_o), 0);
        check("R1 busy", int'(busy_o), 0);
        check("R1 done", int'(done_o), 0);
        check("R1 fail", int'(fail_o), 0);
    endtask

    // Run one clear; release_k < 0 keeps the slave stuck throughout.
    task automatic run_clear(input string tag, input int hp, input int release_k,
                             input bit mid_poke);
        int d = (hp == 0) ? 1 : hp;
        int mism = 0;
        int pulses = 0;
        logic prev_scl = 1'b0;
        bit exp_fail = (release_k < 0);
        @(negedge clk);
        hold = 1'b1;
        half_period_i = CNT_W'(hp);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < NPH * d; k++) begin
            if (k > 0) @(negedge clk);
            if (k == release_k) hold = 1'b0;
            if (mid_poke && k == 3) begin start_i = 1'b1; half_period_i = CNT_W'(hp + 5); end
            if (mid_poke && k == 4) start_i = 1'b0;
            if ({scl_drive_o, sda_drive_o} != exp_drive(k / d) || !busy_o || done_o) mism++;
            if (scl_drive_o && !prev_scl) pulses++;
            prev_scl = scl_drive_o;
        end
        // R3 R4: waveform, order and phase lengths; R6 R7 in the poked run.
        check({tag, " R3 R4 waveform"}, mism, 0);
        check({tag, " R2 scl pulses"}, pulses, NPULSE);
        @(negedge clk);
        check({tag, " R3 busy end"}, int'(busy_o), 0);
        check({tag, " R5 done"}, int'(done_o), 1);
        check({tag, " R5 fail"}, int'(fail_o), int'(exp_fail));
        @(negedge clk);
        check({tag, " R5 done drop"}, int'(done_o), 0);
        check({tag, " R5 fail held"}, int'(fail_o), int'(exp_fail));
        hold = 1'b0;
    endtask

    // R8: start with SDA already high.
    task automatic run_skip();
        @(negedge clk);
        hold = 1'b0;
        half_period_i = CNT_W'(4);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R8 busy", int'(busy_o), 0);
        check("R8 done", int'(done_o), 1);
        check("R8 fail", int'(fail_o), 0);
        check("R8 scl", int'(scl_drive_o), 0);
        @(negedge clk);
        check("R8 done drop", int'(done_o), 0);
        check("R8 busy stays", int'(busy_o), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_reset();
        run_clear("stuck d1", 1, -1, 1'b0);
        run_clear("freed d3", 3, 20, 1'b0);
        run_clear("zero len", 0, 5, 1'b0);
        run_clear("poke R6 R7", 2, 10, 1'b1);
        run_skip();
        run_clear("stuck again", 2, -1, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule